// File: doc/BRIEF.md
# Sixteen-Point Radix-4 FFT Core with Accumulated Twiddle Phases

This block computes a 16-point forward complex DFT of one frame at a time. Samples stream in through a valid-qualified port and land in a 16-entry working buffer in natural order. Two radix-4 passes then run in place on a single pipelined butterfly, four butterflies per pass. The spectrum then streams out in natural frequency order, each bin tagged with its index.

The butterfly applies its twiddle rotations with a shift-and-add rotator. Three phase accumulators produce the rotation angles while butterflies are issued, so no twiddle values and no angle table are held anywhere. Each pass scales its outputs by 1/4, which makes the whole transform scale by 1/16. Between passes the controller waits out the butterfly latency. While a frame is being processed the core raises a busy flag, and it drops any input offered during that time.

Top module: `fft16_r4_core`

## Requirements
- R1: After reset `busy_o` and `out_valid_o` are low. No bin is emitted until sixteen samples have been accepted.
- R2: Each bin equals X[k]/16 within ±4 LSB on both the real and imaginary parts, where X[k] = Σ x[n]·e^(−j2πnk/16) and x[n] is the n-th accepted sample (real part from `in_re_i`, imaginary part from `in_im_i`, 16-bit two's complement).
- R3: A frame is emitted over 16 consecutive cycles with `out_valid_o` high. `out_idx_o` runs 0, 1, …, 15 in that order.
- R4: `busy_o` goes high in the cycle after the 16th sample is accepted and stays high for exactly 30 cycles. It is low in the cycle that carries bin 15.
- R5: While `busy_o` is high, `in_valid_i` has no effect. Data offered then alters neither the frame in flight nor the next frame.
- R6: Bin 0 appears in the 16th cycle after the clock edge that accepted the 16th sample.
- R7: In the first pass, butterfly b (0..3) rotates its outputs m = 1, 2, 3 by b·m·(−1/16 turn). A full turn is 2^16 phase units. Three accumulators produce these angles; they step by m·(−4096) per butterfly and clear at the start of each pass. In the second pass all angles are zero.
- R8: The second pass reads no operand until every first-pass result has been written back.
- R9: Cycles with `in_valid_i` low during loading are skipped. The sample index advances only on accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Sample offered this cycle |
| in_re_i | input | 16 | Sample real part, signed |
| in_im_i | input | 16 | Sample imaginary part, signed |
| busy_o | output | 1 | Frame in process; input refused |
| out_valid_o | output | 1 | Bin valid this cycle |
| out_idx_o | output | 4 | Frequency index of the bin |
| out_re_o | output | 16 | Bin real part, scaled by 1/16 |
| out_im_o | output | 16 | Bin imaginary part, scaled by 1/16 |

## Verification
A wrong accumulator step or a missed clear shows up as wrong magnitudes in the bins that depend on the affected butterfly, in the same frame, 16 cycles after the last sample. A drain that is one cycle too short makes the second pass read stale first-pass operands, so most bins of that frame go wrong. A miscounted phase counter moves the first bin away from cycle 16 and changes the length of the busy window, and both are visible at the ports within the same frame. A write that leaks in while busy corrupts the current or the next frame's spectrum, and the bin comparison reports it.

// File: rtl/fft16_pkg.sv
package fft16_pkg;
  localparam int DATA_W  = 16;
  localparam int GUARD_W = 4;
  localparam int PH_W    = 16;   // phase units per full turn = 2**PH_W
  localparam int CORD_IT = 14;
  localparam int NPTS    = 16;
  localparam int RADIX   = 4;
  localparam int NBF     = NPTS / RADIX;
  localparam int BF_LAT  = 3;
  localparam int AW      = $clog2(NPTS);
  localparam int BW      = $clog2(RADIX);   // AW == 2*BW: two base-4 digits
  localparam int SW      = DATA_W + GUARD_W + 3;
  localparam logic [PH_W-1:0] PH_STEP = PH_W'((1 << PH_W) - (1 << (PH_W - AW)));

  typedef struct packed {
    logic signed [DATA_W-1:0] re;
    logic signed [DATA_W-1:0] im;
  } cplx_t;

  typedef enum logic [2:0] {
    PH_LOAD, PH_RUN1, PH_DRAIN1, PH_RUN2, PH_DRAIN2, PH_UNLOAD
  } phase_e;

  // arctan(2^-i) in units of 2^-16 turn
  function automatic logic [PH_W-1:0] atan_step(input int i);
    case (i)
      0: return PH_W'(8192);
      1: return PH_W'(4836);
      2: return PH_W'(2555);
      3: return PH_W'(1297);
      4: return PH_W'(651);
      5: return PH_W'(326);
      6: return PH_W'(163);
      7: return PH_W'(81);
      8: return PH_W'(41);
      9: return PH_W'(20);
      10: return PH_W'(10);
      11: return PH_W'(5);
      12: return PH_W'(3);
      13: return PH_W'(1);
      default: return '0;
    endcase
  endfunction

  // pass 1: strided group {m,b}; pass 2: contiguous group {b,m}
  function automatic logic [AW-1:0] bf_addr(input logic st2, input logic [BW-1:0] b,
                                            input logic [BW-1:0] m);
    return st2 ? {b, m} : {m, b};
  endfunction

  function automatic logic [AW-1:0] digit_swap(input logic [AW-1:0] k);
    return {k[BW-1:0], k[AW-1:BW]};
  endfunction
endpackage

// File: rtl/fft16_rot.sv
module fft16_rot
  import fft16_pkg::*;
#(
  parameter int IW = SW
) (
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic [PH_W-1:0]      ph_i,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o
);
  localparam int CW = IW + 2;
  localparam int PW = CW + 18;
  localparam logic signed [17:0] KINV = 18'sd19899;  // 1/gain, Q15

  logic [1:0]               quad;
  logic signed [PH_W-1:0]   res;
  logic signed [CW-1:0]     xe, ye;
  logic signed [CW-1:0]     xs [CORD_IT+1];
  logic signed [CW-1:0]     ys [CORD_IT+1];
  logic signed [PH_W-1:0]   zs [CORD_IT+1];

  // nearest quarter turn is applied exactly, the residue by iteration
  assign quad = 2'((ph_i + PH_W'(1 << (PH_W - 3))) >> (PH_W - 2));
  assign res  = signed'(ph_i - {quad, {(PH_W-2){1'b0}}});
  assign xe   = CW'(x_i);
  assign ye   = CW'(y_i);

  assign xs[0] = (quad == 2'd1) ? -ye : (quad == 2'd2) ? -xe : (quad == 2'd3) ? ye : xe;
  assign ys[0] = (quad == 2'd1) ? xe : (quad == 2'd2) ? -ye : (quad == 2'd3) ? -xe : ye;
  assign zs[0] = res;

  for (genvar i = 0; i < CORD_IT; i++) begin : g_it
    logic up;
    logic signed [PH_W-1:0] ang;
    assign up  = ~zs[i][PH_W-1];
    assign ang = signed'(atan_step(i));
    assign xs[i+1] = up ? xs[i] - (ys[i] >>> i) : xs[i] + (ys[i] >>> i);
    assign ys[i+1] = up ? ys[i] + (xs[i] >>> i) : ys[i] - (xs[i] >>> i);
    assign zs[i+1] = up ? zs[i] - ang : zs[i] + ang;
  end

  assign x_o = IW'((PW'(xs[CORD_IT]) * PW'(KINV)) >>> 15);
  assign y_o = IW'((PW'(ys[CORD_IT]) * PW'(KINV)) >>> 15);
endmodule

// File: rtl/fft16_twid_acc.sv
module fft16_twid_acc
  import fft16_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            clr_i,
  input  logic                            step_i,
  input  logic                            st2_i,
  output logic [RADIX-2:0][PH_W-1:0]      ph_o
);
  for (genvar m = 1; m < RADIX; m++) begin : g_acc
    logic [PH_W-1:0] inc;
    logic [PH_W-1:0] acc_q;
    assign inc = st2_i ? '0 : PH_W'(m * int'(PH_STEP));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     acc_q <= '0;
      else if (clr_i)  acc_q <= '0;
      else if (step_i) acc_q <= acc_q + inc;
    end
    assign ph_o[m-1] = acc_q;
  end

  AST_PHASE_RATIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_o[1] == PH_W'(2 * int'(ph_o[0]))) && (ph_o[2] == PH_W'(3 * int'(ph_o[0])))); // R7
  AST_PASS2_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st2_i && step_i) |-> (ph_o == '0)); // R7
endmodule

// File: rtl/fft16_bfly4.sv
module fft16_bfly4
  import fft16_pkg::*;
#(
  parameter int TAG_W = BW + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  input  cplx_t [RADIX-1:0]           in_i,
  input  logic [RADIX-2:0][PH_W-1:0]  ph_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic                        out_valid_o,
  output cplx_t [RADIX-1:0]           out_o,
  output logic [TAG_W-1:0]            tag_o,
  output logic                        busy_o
);
  function automatic logic signed [SW-1:0] ext(input logic signed [DATA_W-1:0] v);
    return SW'(v) <<< GUARD_W;
  endfunction

  function automatic logic signed [DATA_W-1:0] shrink(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] t;
    t = v + SW'(1 << (GUARD_W + 1));
    return DATA_W'(t >>> (GUARD_W + 2));   // round, /4, drop guard
  endfunction

  logic                       v1, v2;
  cplx_t [RADIX-1:0]          a1;
  logic [RADIX-2:0][PH_W-1:0] ph1, ph2;
  logic [TAG_W-1:0]           tag1, tag2;
  logic signed [SW-1:0]       er [RADIX];
  logic signed [SW-1:0]       ei [RADIX];
  logic signed [SW-1:0]       yr [RADIX];
  logic signed [SW-1:0]       yi [RADIX];
  logic signed [SW-1:0]       yr2 [RADIX];
  logic signed [SW-1:0]       yi2 [RADIX];
  logic signed [SW-1:0]       rr [RADIX];
  logic signed [SW-1:0]       ri [RADIX];
  cplx_t [RADIX-1:0]          res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      out_valid_o <= 1'b0;
    end else begin
      v1 <= in_valid_i;
      v2 <= v1;
      out_valid_o <= v2;
    end
  end

  always_ff @(posedge clk_i) begin
    a1   <= in_i;
    ph1  <= ph_i;
    tag1 <= tag_i;
    yr2  <= yr;
    yi2  <= yi;
    ph2  <= ph1;
    tag2 <= tag1;
    out_o <= res;
    tag_o <= tag2;
  end

  for (genvar m = 0; m < RADIX; m++) begin : g_ext
    assign er[m] = ext(a1[m].re);
    assign ei[m] = ext(a1[m].im);
  end

  // 4-point forward DFT, W4 = -j
  assign yr[0] = er[0] + er[1] + er[2] + er[3];
  assign yi[0] = ei[0] + ei[1] + ei[2] + ei[3];
  assign yr[1] = er[0] + ei[1] - er[2] - ei[3];
  assign yi[1] = ei[0] - er[1] - ei[2] + er[3];
  assign yr[2] = er[0] - er[1] + er[2] - er[3];
  assign yi[2] = ei[0] - ei[1] + ei[2] - ei[3];
  assign yr[3] = er[0] - ei[1] - er[2] + ei[3];
  assign yi[3] = ei[0] + er[1] - ei[2] - er[3];

  assign rr[0] = yr2[0];
  assign ri[0] = yi2[0];
  for (genvar m = 1; m < RADIX; m++) begin : g_rot
    fft16_rot #(.IW(SW)) u_rot (
      .x_i (yr2[m]),
      .y_i (yi2[m]),
      .ph_i(ph2[m-1]),
      .x_o (rr[m]),
      .y_o (ri[m])
    );
  end

  for (genvar m = 0; m < RADIX; m++) begin : g_out
    assign res[m].re = shrink(rr[m]);
    assign res[m].im = shrink(ri[m]);
  end

  assign busy_o = v1 | v2 | out_valid_o;
endmodule

// File: rtl/fft16_r4_core.sv
module fft16_r4_core
  import fft16_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_re_i,
  input  logic signed [DATA_W-1:0] in_im_i,
  output logic                     busy_o,
  output logic                     out_valid_o,
  output logic [AW-1:0]            out_idx_o,
  output logic signed [DATA_W-1:0] out_re_o,
  output logic signed [DATA_W-1:0] out_im_o
);
  localparam int TAG_W = BW + 1;

  phase_e                     phase_q, phase_nxt;
  logic [AW-1:0]              cnt_q, cnt_lim;
  logic                       adv;
  cplx_t                      buf_q [NPTS];
  logic                       issue, st2, load_we;
  cplx_t [RADIX-1:0]          bf_in;
  logic [RADIX-2:0][PH_W-1:0] ph;
  logic                       wb_valid, bf_busy;
  cplx_t [RADIX-1:0]          wb_data;
  logic [TAG_W-1:0]           wb_tag;
  cplx_t                      rd_out;

  always_comb begin
    adv       = 1'b1;
    cnt_lim   = AW'(NPTS - 1);
    phase_nxt = PH_LOAD;
    unique case (phase_q)
      PH_LOAD:   begin adv = in_valid_i; phase_nxt = PH_RUN1; end
      PH_RUN1:   begin cnt_lim = AW'(NBF - 1);    phase_nxt = PH_DRAIN1; end
      PH_DRAIN1: begin cnt_lim = AW'(BF_LAT - 1); phase_nxt = PH_RUN2; end
      PH_RUN2:   begin cnt_lim = AW'(NBF - 1);    phase_nxt = PH_DRAIN2; end
      PH_DRAIN2: begin cnt_lim = AW'(BF_LAT - 1); phase_nxt = PH_UNLOAD; end
      default:   phase_nxt = PH_LOAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
    end else if (adv) begin
      if (cnt_q == cnt_lim) begin
        phase_q <= phase_nxt;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + AW'(1);
      end
    end
  end

  assign issue   = (phase_q == PH_RUN1) || (phase_q == PH_RUN2);
  assign st2     = (phase_q == PH_RUN2);
  assign load_we = (phase_q == PH_LOAD) && in_valid_i;
  assign busy_o  = (phase_q != PH_LOAD);

  for (genvar m = 0; m < RADIX; m++) begin : g_rd
    assign bf_in[m] = buf_q[bf_addr(st2, cnt_q[BW-1:0], BW'(m))];
  end

  fft16_twid_acc u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!issue),
    .step_i(issue),
    .st2_i (st2),
    .ph_o  (ph)
  );

  fft16_bfly4 #(.TAG_W(TAG_W)) u_bfly (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (issue),
    .in_i       (bf_in),
    .ph_i       (ph),
    .tag_i      ({st2, cnt_q[BW-1:0]}),
    .out_valid_o(wb_valid),
    .out_o      (wb_data),
    .tag_o      (wb_tag),
    .busy_o     (bf_busy)
  );

  // load and write-back never overlap: write-back only outside PH_LOAD
  always_ff @(posedge clk_i) begin
    if (load_we) buf_q[cnt_q] <= '{re: in_re_i, im: in_im_i};
    if (wb_valid) begin
      for (int m = 0; m < RADIX; m++)
        buf_q[bf_addr(wb_tag[BW], wb_tag[BW-1:0], BW'(m))] <= wb_data[m];
    end
  end

  assign rd_out = buf_q[digit_swap(cnt_q)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_idx_o   <= '0;
      out_re_o    <= '0;
      out_im_o    <= '0;
    end else begin
      out_valid_o <= (phase_q == PH_UNLOAD);
      out_idx_o   <= cnt_q;
      out_re_o    <= rd_out.re;
      out_im_o    <= rd_out.im;
    end
  end

  AST_PASS2_AFTER_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st2 && cnt_q == '0) |-> !bf_busy); // R8
  AST_WB_IN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid |-> (phase_q != PH_LOAD && phase_q != PH_UNLOAD)); // R8
  AST_OUT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> (out_idx_o == '0)); // R3
  AST_OUT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(out_valid_o)) |-> (out_idx_o == $past(out_idx_o) + AW'(1))); // R3
  AST_BUSY_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_idx_o != AW'(NPTS - 1)) |-> busy_o); // R4
endmodule

// File: tb/tb_fft16_r4_core.sv
module tb_fft16_r4_core;
  localparam real PI  = 3.14159265358979;
  localparam int  TOL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic busy, out_valid;
  logic [3:0] out_idx;
  logic signed [15:0] out_re, out_im;

  int n_chk = 0, n_err = 0;
  int sx_re [16];
  int sx_im [16];
  int got_re [16];
  int got_im [16];
  bit [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  fft16_r4_core dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_re_i(in_re), .in_im_i(in_im),
    .busy_o(busy), .out_valid_o(out_valid), .out_idx_o(out_idx),
    .out_re_o(out_re), .out_im_o(out_im)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lcg_val();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 32'd4001) - 2000;
  endfunction

  // drive sx_* (gap idle cycles between samples), then watch 40 cycles
  task automatic run_frame(input string name, input int gap, input bit junk);
    int first = -1, nval = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_re = 16'(sx_re[i]); in_im = 16'(sx_im[i]);
      if (i < 15) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0; in_re = 16'sh7fff; in_im = -16'sh7fff;   // R9 data on idle cycles
        end
      end
    end
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      if (junk && j <= 29) begin
        in_valid = 1'b1; in_re = 16'(lcg_val()); in_im = 16'(lcg_val());   // R5
      end else begin
        in_valid = 1'b0;
      end
      chk(busy == (j <= 30), "R4", {name, " busy window"}, int'(busy), int'(j <= 30));
      if (out_valid) begin
        if (first < 0) begin
          first = j;
          chk(j == 16, "R6", {name, " first bin cycle"}, j, 16);
        end
        chk(int'(out_idx) == j - 16, "R3", {name, " bin order"}, int'(out_idx), j - 16);
        got_re[out_idx] = int'(out_re);
        got_im[out_idx] = int'(out_im);
        nval++;
      end
    end
    chk(nval == 16, "R3", {name, " bins emitted"}, nval, 16);
    for (int k = 0; k < 16; k++) begin
      real er = 0.0, ei = 0.0;
      int  xr, xi;
      for (int n = 0; n < 16; n++) begin
        real th = 2.0 * PI * real'(n * k) / 16.0;
        er += real'(sx_re[n]) * $cos(th) + real'(sx_im[n]) * $sin(th);
        ei += real'(sx_im[n]) * $cos(th) - real'(sx_re[n]) * $sin(th);
      end
      xr = int'(er / 16.0);
      xi = int'(ei / 16.0);
      chk((got_re[k] - xr <= TOL) && (xr - got_re[k] <= TOL), "R2 R7 R8",
          $sformatf("%s bin %0d re", name, k), got_re[k], xr);
      chk((got_im[k] - xi <= TOL) && (xi - got_im[k] <= TOL), "R2 R7 R8",
          $sformatf("%s bin %0d im", name, k), got_im[k], xi);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_partial_idle();
    // 15 samples only: core must stay idle and silent
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_re = 16'(100 * i); in_im = '0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      chk(!out_valid && !busy, "R1", "idle with 15 samples", int'(out_valid | busy), 0);
    end
    // 16th sample completes the frame: impulse at n=15 is not the content, so reload
    @(negedge clk);
    in_valid = 1'b1; in_re = '0; in_im = '0;
    @(negedge clk);
    in_valid = 1'b0;
    wait (!busy);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_impulse();
    for (int n = 0; n < 16; n++) begin sx_re[n] = 0; sx_im[n] = 0; end
    sx_re[0] = 1600;
    run_frame("impulse", 0, 1'b0);
  endtask

  task automatic t_tone();
    for (int n = 0; n < 16; n++) begin
      sx_re[n] = int'(1500.0 * $cos(2.0 * PI * 3.0 * real'(n) / 16.0));
      sx_im[n] = int'(1500.0 * $sin(2.0 * PI * 3.0 * real'(n) / 16.0));
    end
    run_frame("tone3", 0, 1'b0);
  endtask

  task automatic t_random_gaps();
    for (int n = 0; n < 16; n++) begin sx_re[n] = lcg_val(); sx_im[n] = lcg_val(); end
    run_frame("random_gap2", 2, 1'b0);   // R9
  endtask

  task automatic t_junk_while_busy();
    for (int n = 0; n < 16; n++) begin sx_re[n] = 120 * n - 900; sx_im[n] = 700 - 50 * n; end
    run_frame("ramp_junk", 0, 1'b1);     // R5 current frame
    for (int n = 0; n < 16; n++) begin sx_re[n] = (n % 3) * 800 - 600; sx_im[n] = 0; end
    run_frame("after_junk", 1, 1'b0);    // R5 next frame
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_err++;
    $display("FAIL R6 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_partial_idle();
    t_impulse();
    t_tone();
    t_random_gaps();
    t_junk_while_busy();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule